// File: doc/BRIEF.md
# Parallel Load-Store Address Unit

This unit executes the parallel-memory extension slot of a 16-bit DSP instruction. While the main instruction runs, the low byte of the instruction word can ask for one load and one store in the same cycle. Each access goes through its own address pointer.

The load reads the data word that pointer three addresses. That word goes out on a register-file write port aimed at one of four registers, numbered 0x18 to 0x1B. The store writes the middle word of one of two accumulators to the address held in pointer zero. Both addresses come from the pointer values at the start of the cycle.

At the clock edge each pointer steps forward. It moves either by one or by its own index register, and the two pointers choose independently. The data-memory port is single-cycle: read data returned in a cycle is passed straight to the register write port in that cycle, and the write takes effect at the clock edge. The main datapath can load either pointer through a set port. A set in a cycle wins over the post-step of the same pointer.

Top module: `ldst_agu`

## Requirements
- R1: An operation is recognised only when `op_valid` is 1, `rst_n` is 1, `op_byte[7:6]` is 2'b10 and `op_byte[1]` is 0. Otherwise `mem_re`, `mem_we` and `dst_we` stay 0, and pointers change only through the set port.
- R2: For a recognised operation, in the same cycle, `mem_re` is 1 and `mem_raddr` equals pointer three as it stood before the cycle. `dst_we` is 1, `dst_idx` equals 0x18 plus `op_byte[5:4]`, and `dst_data` equals `mem_rdata`.
- R3: For a recognised operation, in the same cycle, `mem_we` is 1 and `mem_waddr` equals pointer zero as it stood before the cycle. `mem_wdata` is `acc0_mid` when `op_byte[0]` is 0 and `acc1_mid` when it is 1.
- R4: After a recognised operation, pointer zero (`ar0_q`) becomes its old value plus 1 when `op_byte[2]` is 0, and plus `ix0` when `op_byte[2]` is 1. The change is visible after the clock edge.
- R5: After a recognised operation, pointer three (`ar3_q`) becomes its old value plus 1 when `op_byte[3]` is 0, and plus `ix3` when `op_byte[3]` is 1. The 3-bit code `op_byte[3:1]` = 110 therefore steps both pointers by their index registers.
- R6: All pointer arithmetic wraps modulo 2^16. An index of 0xFFFE acts as a step of minus two.
- R7: Setting `ptr_set_en[0]` loads `ptr_set_val` into pointer zero, and setting `ptr_set_en[1]` loads it into pointer three, at the clock edge. A set overrides the post-step of the same pointer in that cycle.
- R8: Reset is synchronous and active low. It clears both pointers to 0. While reset is low, no memory access or register write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Qualifies `op_byte` this cycle |
| op_byte | input | 8 | Low byte of the instruction word (extension field) |
| acc0_mid | input | 16 | Middle word of accumulator 0 |
| acc1_mid | input | 16 | Middle word of accumulator 1 |
| ix0 | input | 16 | Index register paired with pointer zero |
| ix3 | input | 16 | Index register paired with pointer three |
| ptr_set_en | input | 2 | Set strobes: bit 0 pointer zero, bit 1 pointer three |
| ptr_set_val | input | 16 | Value loaded by a set strobe |
| mem_rdata | input | 16 | Data-memory read data, same cycle |
| mem_re | output | 1 | Data-memory read strobe |
| mem_raddr | output | 16 | Data-memory read address |
| mem_we | output | 1 | Data-memory write strobe |
| mem_waddr | output | 16 | Data-memory write address |
| mem_wdata | output | 16 | Data-memory write data |
| dst_we | output | 1 | Register-file write strobe for the loaded word |
| dst_idx | output | 5 | Register number written (0x18 to 0x1B) |
| dst_data | output | 16 | Loaded word to write |
| ar0_q | output | 16 | Current value of pointer zero |
| ar3_q | output | 16 | Current value of pointer three |

## Verification
The main function is driven with all four step modes. Distinct pointer, index and accumulator values are used, so that a swapped pointer, a swapped index or a wrong accumulator select each gives a different wrong address or data word. Every destination code is used, which exposes a shifted or mis-based register number. Wrap cases and a negative index separate modular arithmetic from saturating or sign-confused arithmetic. Bytes with a wrong prefix, bytes with bit 1 set, a dropped valid, and reset with a valid operation must all leave memory, the register port and the pointers untouched. A set that collides with a post-step shows which of the two takes priority.

// File: rtl/ldst_pkg.sv
// Shared constants and decoded-control type for the parallel load-store unit.
// Assumes the extension field occupies the low byte of the instruction word.
package ldst_pkg;
    localparam int REG_IDX_W = 5;
    localparam logic [REG_IDX_W-1:0] LOAD_GROUP_BASE = 5'h18;
    localparam logic [1:0] EXT_PREFIX = 2'b10;

    typedef struct packed {
        logic       hit;      // operation recognised this cycle
        logic [1:0] dsel;     // load destination offset in the group
        logic       idx_p0;   // pointer zero steps by its index
        logic       idx_p3;   // pointer three steps by its index
        logic       acc_sel;  // accumulator supplying store data
    } ext_ctl_t;
endpackage

// File: rtl/ldst_decode.sv
// Decodes the extension byte into load/store controls.
// Assumes op_byte[7:6] is the family prefix and op_byte[1] must be 0;
// the enable input already folds in reset.
module ldst_decode
    import ldst_pkg::*;
(
    input  logic       enable,
    input  logic [7:0] op_byte,
    output ext_ctl_t   ctl
);
    // Field extraction and recognition of the load-store family.
    always_comb begin
        ctl.hit     = enable && (op_byte[7:6] == EXT_PREFIX) && !op_byte[1];
        ctl.dsel    = op_byte[5:4];
        ctl.idx_p0  = op_byte[2];
        ctl.idx_p3  = op_byte[3];
        ctl.acc_sel = op_byte[0];
    end
endmodule

// File: rtl/ldst_ptr.sv
// One address pointer with post-step by one or by an index, and a set port.
// Assumes set_en and step_en are already gated by reset; set wins over step.
module ldst_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              use_idx,
    input  logic [ADDR_W-1:0] idx,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_val,
    output logic [ADDR_W-1:0] q
);
    logic [ADDR_W-1:0] step_amt;

    // Choose the post-step amount.
    always_comb step_amt = use_idx ? idx : ADDR_W'(1);

    // Pointer register: reset, set, post-step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (set_en)  q <= set_val;
        else if (step_en) q <= q + step_amt;
    end

    // R4 / R5 / R6: a step without a set moves by one or the index, modulo 2^ADDR_W
    a_r4_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !set_en) |=>
        q == ADDR_W'($past(q) + ($past(use_idx) ? $past(idx) : ADDR_W'(1))));

    // R7: a set always lands, even against a step
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> q == $past(set_val));

    // R1: no step and no set leaves the pointer alone
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !set_en) |=> $stable(q));

    // R8: reset clears the pointer
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> q == '0);
endmodule

// File: rtl/ldst_agu.sv
// Parallel load-store address unit: one load through pointer three and one
// store through pointer zero per cycle, then independent post-steps.
// Assumes a single-cycle data-memory port (read data valid in the same cycle).
module ldst_agu
    import ldst_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [7:0]           op_byte,
    input  logic [DATA_W-1:0]    acc0_mid,
    input  logic [DATA_W-1:0]    acc1_mid,
    input  logic [ADDR_W-1:0]    ix0,
    input  logic [ADDR_W-1:0]    ix3,
    input  logic [1:0]           ptr_set_en,
    input  logic [ADDR_W-1:0]    ptr_set_val,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 mem_re,
    output logic [ADDR_W-1:0]    mem_raddr,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_waddr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 dst_we,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic [DATA_W-1:0]    dst_data,
    output logic [ADDR_W-1:0]    ar0_q,
    output logic [ADDR_W-1:0]    ar3_q
);
    localparam int NPTR = 2;   // slot 0: pointer zero (store), slot 1: pointer three (load)

    ext_ctl_t          ctl;
    logic [ADDR_W-1:0] p_q   [NPTR];
    logic [ADDR_W-1:0] p_idx [NPTR];
    logic              p_use [NPTR];

    ldst_decode u_dec (
        .enable  (op_valid && rst_n),
        .op_byte (op_byte),
        .ctl     (ctl)
    );

    // Route each pointer slot to its index register and mode bit.
    always_comb begin
        p_idx[0] = ix0;
        p_idx[1] = ix3;
        p_use[0] = ctl.idx_p0;
        p_use[1] = ctl.idx_p3;
    end

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        ldst_ptr #(.ADDR_W(ADDR_W)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (ctl.hit),
            .use_idx (p_use[i]),
            .idx     (p_idx[i]),
            .set_en  (ptr_set_en[i] && rst_n),
            .set_val (ptr_set_val),
            .q       (p_q[i])
        );
    end

    // Memory and register-port drive from pre-update pointer values.
    always_comb begin
        ar0_q     = p_q[0];
        ar3_q     = p_q[1];
        mem_re    = ctl.hit;
        mem_raddr = p_q[1];
        mem_we    = ctl.hit;
        mem_waddr = p_q[0];
        mem_wdata = ctl.acc_sel ? acc1_mid : acc0_mid;
        dst_we    = ctl.hit;
        dst_idx   = LOAD_GROUP_BASE + REG_IDX_W'(ctl.dsel);
        dst_data  = mem_rdata;
    end

    // R3: a store always targets pointer zero's current value
    a_r3_store_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_waddr == ar0_q);

    // R2: a load always reads pointer three and writes into the 0x18 group
    a_r2_load_path: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (mem_raddr == ar3_q) && mem_re && (dst_idx[4:2] == 3'b110));

    // R8: nothing issued while reset is low
    a_r8_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> !mem_we && !dst_we && !mem_re);
endmodule

// File: tb/sim_ldst_agu.sv
module sim_ldst_agu;
    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] a0, a3, i0, i3, c0, c1, rd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{8'h80, 16'h0100, 16'h0200, 16'h0005, 16'h0007, 16'hA001, 16'hB001, 16'h1111}, // both +1, D0, acc0
        '{8'h99, 16'h0300, 16'h0400, 16'h0011, 16'h0013, 16'hA002, 16'hB002, 16'h2222}, // ar3 indexed, D1, acc1
        '{8'hAD, 16'h0500, 16'h0600, 16'h0021, 16'h0023, 16'hA003, 16'hB003, 16'h3333}, // code 110: both indexed, D2
        '{8'hB4, 16'h0700, 16'h0800, 16'h0031, 16'h0033, 16'hA004, 16'hB004, 16'h4444}, // ar0 indexed, D3
        '{8'h88, 16'hFFFF, 16'hFFF0, 16'h0041, 16'h0020, 16'hA005, 16'hB005, 16'h5555}, // wrap both
        '{8'h84, 16'h0001, 16'h0010, 16'hFFFE, 16'h0001, 16'hA006, 16'hB006, 16'h6666}, // negative index
        '{8'h8C, 16'hFFF8, 16'h0002, 16'h0010, 16'hFFFD, 16'hA007, 16'hB007, 16'h7777}, // both indexed wrap/neg
        '{8'h82, 16'h0123, 16'h0456, 16'h0009, 16'h0009, 16'hA008, 16'hB008, 16'h8888}, // bit1 set: ignored
        '{8'h4C, 16'h0135, 16'h0246, 16'h0009, 16'h0009, 16'hA009, 16'hB009, 16'h9999}, // prefix 01: ignored
        '{8'hC0, 16'h0357, 16'h0468, 16'h0009, 16'h0009, 16'hA00A, 16'hB00A, 16'hAAAA}  // prefix 11: ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_byte = '0;
    logic [15:0] acc0_mid = '0, acc1_mid = '0, ix0 = '0, ix3 = '0;
    logic [1:0]  ptr_set_en = '0;
    logic [15:0] ptr_set_val = '0, mem_rdata = '0;
    logic        mem_re, mem_we, dst_we;
    logic [15:0] mem_raddr, mem_waddr, mem_wdata, dst_data, ar0_q, ar3_q;
    logic [4:0]  dst_idx;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    ldst_agu u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .acc0_mid(acc0_mid), .acc1_mid(acc1_mid), .ix0(ix0), .ix3(ix3),
        .ptr_set_en(ptr_set_en), .ptr_set_val(ptr_set_val), .mem_rdata(mem_rdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
        .ar0_q(ar0_q), .ar3_q(ar3_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Load both pointers through the set port (two cycles, on negedges).
    task automatic load_ptrs(input logic [15:0] a0, input logic [15:0] a3);
        @(negedge clk);
        ptr_set_en = 2'b01; ptr_set_val = a0;
        @(negedge clk);
        ptr_set_en = 2'b10; ptr_set_val = a3;
        @(negedge clk);
        ptr_set_en = 2'b00;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R8: reset state, with a valid operation held during reset
        op_valid = 1'b1; op_byte = 8'h80;
        repeat (3) @(negedge clk);
        chk("R8 no write in reset", {31'd0, mem_we}, 32'd0);
        chk("R8 no load in reset", {31'd0, dst_we}, 32'd0);
        chk("R8 ar0 cleared", {16'd0, ar0_q}, 32'd0);
        chk("R8 ar3 cleared", {16'd0, ar3_q}, 32'd0);
        op_valid = 1'b0;
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            logic hit;
            logic [15:0] e0, e3;
            load_ptrs(TBL[k].a0, TBL[k].a3);
            chk("R7 set ar0", {16'd0, ar0_q}, {16'd0, TBL[k].a0});
            chk("R7 set ar3", {16'd0, ar3_q}, {16'd0, TBL[k].a3});
            op_valid = 1'b1; op_byte = TBL[k].op;
            ix0 = TBL[k].i0; ix3 = TBL[k].i3;
            acc0_mid = TBL[k].c0; acc1_mid = TBL[k].c1; mem_rdata = TBL[k].rd;
            hit = (TBL[k].op[7:6] == 2'b10) && !TBL[k].op[1];
            #5;
            if (hit) begin
                chk("R2 mem_re", {31'd0, mem_re}, 32'd1);
                chk("R2 raddr", {16'd0, mem_raddr}, {16'd0, TBL[k].a3});
                chk("R2 dst_we", {31'd0, dst_we}, 32'd1);
                chk("R2 dst_idx", {27'd0, dst_idx}, 32'h18 + {30'd0, TBL[k].op[5:4]});
                chk("R2 dst_data", {16'd0, dst_data}, {16'd0, TBL[k].rd});
                chk("R3 mem_we", {31'd0, mem_we}, 32'd1);
                chk("R3 waddr", {16'd0, mem_waddr}, {16'd0, TBL[k].a0});
                chk("R3 wdata", {16'd0, mem_wdata},
                    {16'd0, TBL[k].op[0] ? TBL[k].c1 : TBL[k].c0});
                e0 = TBL[k].a0 + (TBL[k].op[2] ? TBL[k].i0 : 16'd1);
                e3 = TBL[k].a3 + (TBL[k].op[3] ? TBL[k].i3 : 16'd1);
            end else begin
                chk("R1 ignored no write", {31'd0, mem_we}, 32'd0);
                chk("R1 ignored no load", {30'd0, dst_we, mem_re}, 32'd0);
                e0 = TBL[k].a0;
                e3 = TBL[k].a3;
            end
            @(negedge clk);
            op_valid = 1'b0;
            chk("R4 R6 ar0 after step", {16'd0, ar0_q}, {16'd0, e0});
            chk("R5 R6 ar3 after step", {16'd0, ar3_q}, {16'd0, e3});
        end

        // R1: valid low with a well-formed byte
        load_ptrs(16'h1000, 16'h2000);
        op_valid = 1'b0; op_byte = 8'hAC;
        #5;
        chk("R1 valid low no write", {31'd0, mem_we}, 32'd0);
        chk("R1 valid low no load", {31'd0, dst_we}, 32'd0);
        @(negedge clk);
        chk("R1 valid low ar0 held", {16'd0, ar0_q}, 32'h1000);
        chk("R1 valid low ar3 held", {16'd0, ar3_q}, 32'h2000);

        // R7: set on pointer zero collides with a step of both pointers
        op_valid = 1'b1; op_byte = 8'h80; ptr_set_en = 2'b01; ptr_set_val = 16'h5555;
        #5;
        chk("R7 store uses old ar0", {16'd0, mem_waddr}, 32'h1000);
        @(negedge clk);
        op_valid = 1'b0; ptr_set_en = 2'b00;
        chk("R7 set beats step", {16'd0, ar0_q}, 32'h5555);
        chk("R7 other pointer still steps", {16'd0, ar3_q}, 32'h2001);

        // R8: reset mid-run clears the pointers
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 ar0 cleared again", {16'd0, ar0_q}, 32'd0);
        chk("R8 ar3 cleared again", {16'd0, ar3_q}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule